// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software programs a timeout length, arms the watchdog and must then keep writing a magic restart value before the countdown runs out. The countdown advances on a slow timebase strobe (nominally 32 kHz) that arrives as a one-cycle input pulse. The timeout is programmed in coarse units of 512 ticks.

When the countdown expires, the block either drives a fixed-length reset pulse on an output whose active level software selects, or raises a sticky interrupt. Software can also force the reset pulse at once by writing a second magic value. Every register that changes the watchdog has its own key pattern, so a stray store with the wrong pattern changes nothing. A status register records whether the last event was a timeout or a software-forced reset.

The bus is a simple single-cycle write strobe with address and data. Read data is combinational on the address.

Top module: `guard_wdt`

## Requirements
- R1: After reset the control register (byte offset 0x00) and status register (0x0C) read 0, the length register (0x04) reads `LEN_RST` in bits 5 and up, `irq_o` is 0 and `wdt_rst_o` is 1 (inactive, because the polarity bit resets to 0).
- R2: A write to 0x00 is taken only when data bits 31:24 equal 0x22. It stores enable (bit 0), output polarity (bit 1), reset-output enable (bit 2), interrupt-instead-of-reset (bit 3) and a stored-only dual flag (bit 6). A read returns only those bits, all other bits 0.
- R3: A write to 0x04 is taken only when data bits 4:0 equal 0x08. The length field sits in bits 5 up to 5+`LEN_W`-1 and reads back there, with all other bits 0.
- R4: A write of exactly 0x00001971 to 0x08 reloads the countdown with length×512 ticks and re-arms expiry. Any other value written there has no effect on the timing.
- R5: While enabled, the countdown drops by one on each tick. Expiry happens on the tick that brings it to zero, i.e. the length×512-th tick after a restart, and it sets status bit 31.
- R6: On expiry with bit 2 set and bit 3 clear, `wdt_rst_o` is driven to its active level for exactly 16 clocks (`PULSE_LEN`). The active level is high when bit 1 is 1 and low when it is 0.
- R7: On expiry with bit 3 set, `irq_o` rises and stays high, and no reset pulse is produced. Writes to 0x00 without the key leave it high.
- R8: A write of exactly 0x00001209 to 0x14 starts the 16-clock reset pulse in the very next cycle, whatever the enable or count state, and sets status bit 30. Other values written there are ignored.
- R9: With enable cleared, the countdown holds its value and no expiry occurs. Setting enable again resumes the count from the held value.
- R10: A keyed write to 0x00 clears both status bits and the interrupt. An unkeyed write clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe that advances the countdown |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_rst_o | output | 1 | Reset output, active level set by control bit 1 |
| irq_o | output | 1 | Sticky watchdog interrupt |

## Verification
The hardest situations to reach are the exact expiry tick and the count value left behind when enable drops part-way through a countdown. Both are hidden state that only shows up as a pulse edge some hundreds of cycles later. The bench holds the tick strobe high on every clock and uses a one-unit length, which gives a 512-cycle window. It counts clocks from each keyed restart to the first active output cycle and compares that count with the value worked out arithmetically. Pauses, rejected restart values and a re-enable after a disable are placed at known offsets inside that window, so each one moves the expected expiry cycle by a known amount.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

    localparam logic [31:0] OFS_CTRL    = 32'h00;
    localparam logic [31:0] OFS_LEN     = 32'h04;
    localparam logic [31:0] OFS_KICK    = 32'h08;
    localparam logic [31:0] OFS_STAT    = 32'h0C;
    localparam logic [31:0] OFS_FORCE   = 32'h14;

    localparam logic [7:0]  CTRL_KEY    = 8'h22;
    localparam logic [4:0]  LEN_KEY     = 5'h08;
    localparam logic [31:0] KICK_MAGIC  = 32'h0000_1971;
    localparam logic [31:0] FORCE_MAGIC = 32'h0000_1209;

    localparam int LEN_LSB      = 5;
    localparam int STAT_TO_BIT  = 31;
    localparam int STAT_SW_BIT  = 30;

    typedef struct packed {
        logic dual;
        logic irq_sel;
        logic out_en;
        logic pol;
        logic en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_LEN,
        SEL_KICK,
        SEL_STAT,
        SEL_FORCE
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(logic [31:0] a);
        case (a)
            OFS_CTRL:  return SEL_CTRL;
            OFS_LEN:   return SEL_LEN;
            OFS_KICK:  return SEL_KICK;
            OFS_STAT:  return SEL_STAT;
            OFS_FORCE: return SEL_FORCE;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w    = '0;
        w[0] = c.en;
        w[1] = c.pol;
        w[2] = c.out_en;
        w[3] = c.irq_sel;
        w[6] = c.dual;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [31:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.pol     = w[1];
        c.out_en  = w[2];
        c.irq_sel = w[3];
        c.dual    = w[6];
        return c;
    endfunction

endpackage

// File: rtl/guard_wdt_regs.sv
module guard_wdt_regs
    import guard_wdt_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int LEN_W   = 11,
    parameter int LEN_RST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              expire_ev,
    output ctrl_t             ctrl_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              kick_ev,
    output logic              force_ev,
    output logic              ctrl_wr,
    output logic              stat_to,
    output logic              stat_sw,
    output logic              irq_q
);

    reg_sel_t    sel;
    logic        len_wr;
    logic [31:0] len_word;

    always_comb begin
        sel      = decode_addr(32'(bus_addr));
        ctrl_wr  = bus_wr && (sel == SEL_CTRL) && (bus_wdata[31:24] == CTRL_KEY);
        len_wr   = bus_wr && (sel == SEL_LEN) && (bus_wdata[4:0] == LEN_KEY);
        kick_ev  = bus_wr && (sel == SEL_KICK) && (bus_wdata == KICK_MAGIC);
        force_ev = bus_wr && (sel == SEL_FORCE) && (bus_wdata == FORCE_MAGIC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            len_q   <= LEN_W'(LEN_RST);
            stat_to <= 1'b0;
            stat_sw <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= word_to_ctrl(bus_wdata);
            if (len_wr)  len_q  <= bus_wdata[LEN_LSB +: LEN_W];

            if (expire_ev)    stat_to <= 1'b1;
            else if (ctrl_wr) stat_to <= 1'b0;

            if (force_ev)     stat_sw <= 1'b1;
            else if (ctrl_wr) stat_sw <= 1'b0;

            if (expire_ev && ctrl_q.irq_sel) irq_q <= 1'b1;
            else if (ctrl_wr)                irq_q <= 1'b0;
        end
    end

    always_comb begin
        len_word                   = '0;
        len_word[LEN_LSB +: LEN_W] = len_q;
        bus_rdata                  = '0;
        case (sel)
            SEL_CTRL: bus_rdata = ctrl_to_word(ctrl_q);
            SEL_LEN:  bus_rdata = len_word;
            SEL_STAT: begin
                bus_rdata[STAT_TO_BIT] = stat_to;
                bus_rdata[STAT_SW_BIT] = stat_sw;
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/guard_wdt_count.sv
module guard_wdt_count #(
    parameter int LEN_W      = 11,
    parameter int UNIT_SHIFT = 9,
    parameter int LEN_RST    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             reload,
    input  logic [LEN_W-1:0] len,
    output logic             expire_ev
);

    localparam int CNT_W = LEN_W + UNIT_SHIFT;
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(LEN_RST) << UNIT_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             step;

    assign step      = en && tick && !fired_q && !reload;
    assign expire_ev = step && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_RST;
            fired_q <= 1'b0;
        end else if (reload) begin
            cnt_q   <= {len, {UNIT_SHIFT{1'b0}}};
            fired_q <= 1'b0;
        end else if (expire_ev) begin
            cnt_q   <= '0;
            fired_q <= 1'b1;
        end else if (step) begin
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/guard_wdt_pulse.sv
module guard_wdt_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (fire)          left_q <= PW'(PULSE_LEN);
        else if (left_q != '0)  left_q <= left_q - PW'(1);
    end

    assign active = (left_q != '0);

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
    import guard_wdt_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int LEN_W      = 11,
    parameter int UNIT_SHIFT = 9,
    parameter int LEN_RST    = 4,
    parameter int PULSE_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_o,
    output logic              irq_o
);

    ctrl_t            ctrl_q;
    logic [LEN_W-1:0] len_q;
    logic             kick_ev;
    logic             force_ev;
    logic             ctrl_wr;
    logic             stat_to;
    logic             stat_sw;
    logic             irq_q;
    logic             expire_ev;
    logic             pulse_fire;
    logic             pulse_act;

    guard_wdt_regs #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .LEN_RST (LEN_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire_ev (expire_ev),
        .ctrl_q    (ctrl_q),
        .len_q     (len_q),
        .kick_ev   (kick_ev),
        .force_ev  (force_ev),
        .ctrl_wr   (ctrl_wr),
        .stat_to   (stat_to),
        .stat_sw   (stat_sw),
        .irq_q     (irq_q)
    );

    guard_wdt_count #(
        .LEN_W      (LEN_W),
        .UNIT_SHIFT (UNIT_SHIFT),
        .LEN_RST    (LEN_RST)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .en        (ctrl_q.en),
        .reload    (kick_ev),
        .len       (len_q),
        .expire_ev (expire_ev)
    );

    assign pulse_fire = force_ev || (expire_ev && ctrl_q.out_en && !ctrl_q.irq_sel);

    guard_wdt_pulse #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (pulse_fire),
        .active (pulse_act)
    );

    assign wdt_rst_o = ctrl_q.pol ? pulse_act : !pulse_act;
    assign irq_o     = irq_q;

endmodule

// File: rtl/guard_wdt_chk.sv
module guard_wdt_chk
    import guard_wdt_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int LEN_W     = 11,
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              irq_o,
    input ctrl_t             ctrl_q,
    input logic [LEN_W-1:0]  len_q,
    input logic              ctrl_wr,
    input logic              expire_ev,
    input logic              pulse_fire,
    input logic              pulse_act,
    input logic              stat_sw
);

    localparam int RW = $clog2(PULSE_LEN + 1) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= '0;
        else if (pulse_fire) run_q <= '0;
        else if (pulse_act) run_q <= run_q + RW'(1);
        else                run_q <= '0;
    end

    // R2
    a_r2_ctrl_needs_key: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 32'(bus_addr) == OFS_CTRL && bus_wdata[31:24] != CTRL_KEY)
        |=> $stable(ctrl_q));

    // R3
    a_r3_len_needs_key: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 32'(bus_addr) == OFS_LEN && bus_wdata[4:0] != LEN_KEY)
        |=> $stable(len_q));

    // R6
    a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
        pulse_act |-> (run_q < RW'(PULSE_LEN)));

    // R7
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !ctrl_wr) |=> irq_o);

    // R8
    a_r8_force_immediate: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 32'(bus_addr) == OFS_FORCE && bus_wdata == FORCE_MAGIC)
        |=> (pulse_act && stat_sw));

    // R9
    a_r9_no_expiry_when_off: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en |-> !expire_ev);

endmodule

bind guard_wdt guard_wdt_chk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .PULSE_LEN (PULSE_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .ctrl_q     (ctrl_q),
    .len_q      (len_q),
    .ctrl_wr    (ctrl_wr),
    .expire_ev  (expire_ev),
    .pulse_fire (pulse_fire),
    .pulse_act  (pulse_act),
    .stat_sw    (stat_sw)
);

// File: tb/guard_wdt_tb.sv
`timescale 1ns/1ps
module guard_wdt_tb;

    localparam int UNIT = 512;
    localparam int PLEN = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;
    logic        irq_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    logic cur_pol = 1'b0;

    always #2.5 clk = ~clk;

    guard_wdt u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst_o (wdt_rst_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic bit is_active();
        return (wdt_rst_o === cur_pol);
    endfunction

    task automatic wait_active(input int limit, output int n);
        n = 0;
        while (!is_active() && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (is_active() && w < 100) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic set_ctrl(input logic [7:0] bits);
        bus_write(5'h00, {8'h22, 16'h0, bits});
        cur_pol = bits[1];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;
        int w;
        int cnt;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(5'h00, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(5'h0C, rd); check("R1 status", rd, 32'h0);
        bus_read(5'h04, rd); check("R1 length", rd, 32'd4 << 5);
        check("R1 rst_o", 32'(wdt_rst_o), 32'h1);
        check("R1 irq", 32'(irq_o), 32'h0);

        // R2 key sweep over all 256 key bytes
        for (int k = 0; k < 256; k++) begin
            bus_write(5'h00, 32'h2200_0000);
            bus_write(5'h00, {k[7:0], 24'hFFFF4E});
            bus_read(5'h00, rd);
            check("R2 ctrl key", rd, (k == 8'h22) ? 32'h4E : 32'h0);
        end
        bus_write(5'h00, 32'h2200_0000);
        cur_pol = 1'b0;

        // R3 low-bit key sweep
        for (int j = 0; j < 32; j++) begin
            bus_write(5'h04, 32'h8);
            bus_write(5'h04, (32'd21 << 5) | 32'(j));
            bus_read(5'h04, rd);
            check("R3 len key", rd, (j == 8) ? (32'd21 << 5) : 32'h0);
        end

        // R5/R6 expiry timing and pulse for lengths 1..3, alternating polarity
        for (int L = 1; L <= 3; L++) begin
            bus_write(5'h04, (32'(L) << 5) | 32'h8);
            set_ctrl(8'h05 | (L[0] ? 8'h02 : 8'h00));
            bus_write(5'h08, 32'h1971);
            wait_active(5000, n);
            check("R5 expiry cycles", n, L * UNIT);
            pulse_width(w);
            check("R6 pulse width", w, PLEN);
            check("R6 inactive level", 32'(wdt_rst_o), 32'(!cur_pol));
            bus_read(5'h0C, rd); check("R5 status timeout", rd, 32'h8000_0000);
            if (L == 1) begin
                bus_write(5'h00, 32'h2100_0000);
                bus_read(5'h0C, rd); check("R10 unkeyed keeps status", rd, 32'h8000_0000);
            end
            set_ctrl(8'h00);
            bus_read(5'h0C, rd); check("R10 keyed clears status", rd, 32'h0);
        end

        // R4 rejected restart values do not move expiry
        bus_write(5'h04, (32'd1 << 5) | 32'h8);
        set_ctrl(8'h07);
        bus_write(5'h08, 32'h1971);
        repeat (100) @(negedge clk);
        bus_write(5'h08, 32'h1970);
        bus_write(5'h08, 32'h0001_1971);
        wait_active(5000, n);
        check("R4 bad restart ignored", n, UNIT - 104);
        pulse_width(w);
        set_ctrl(8'h00);

        // R4 good restart mid-count reloads
        set_ctrl(8'h07);
        bus_write(5'h08, 32'h1971);
        repeat (300) @(negedge clk);
        bus_write(5'h08, 32'h1971);
        wait_active(5000, n);
        check("R4 restart reloads", n, UNIT);
        pulse_width(w);
        set_ctrl(8'h00);

        // R9 disable holds count, re-enable resumes
        set_ctrl(8'h07);
        bus_write(5'h08, 32'h1971);
        repeat (100) @(negedge clk);
        set_ctrl(8'h06);
        wait_active(1500, n);
        check("R9 no expiry when disabled", n, 1500);
        bus_read(5'h0C, rd); check("R9 status idle", rd, 32'h0);
        set_ctrl(8'h07);
        wait_active(5000, n);
        check("R9 resume from held count", n, UNIT - 102);
        pulse_width(w);
        set_ctrl(8'h00);

        // R7 interrupt instead of reset
        set_ctrl(8'h0F);
        bus_write(5'h08, 32'h1971);
        cnt = 0;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (is_active()) cnt++;
        end
        check("R7 no reset pulse", cnt, 0);
        check("R7 irq raised", 32'(irq_o), 32'h1);
        bus_write(5'h00, 32'h0000_0000);
        check("R7 irq sticky on unkeyed write", 32'(irq_o), 32'h1);
        set_ctrl(8'h00);
        check("R10 keyed clears irq", 32'(irq_o), 32'h0);

        // R8 software-forced reset
        bus_write(5'h14, 32'h1208);
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (is_active()) cnt++;
        end
        check("R8 wrong force value ignored", cnt, 0);
        bus_write(5'h14, 32'h1209);
        wait_active(5, n);
        check("R8 immediate pulse", n, 0);
        pulse_width(w);
        check("R8 pulse width", w, PLEN);
        bus_read(5'h0C, rd); check("R8 status force", rd, 32'h4000_0000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule